// File: doc/BRIEF.md
# Timestamped Cluster Sample Expander

This block turns run-length compressed capture memory back into a plain stream with one sample per sample period. The memory is read as a stream of 16-bit words grouped in clusters. Each cluster starts with a timestamp word and is followed by a fixed number of event words. When a cluster's timestamp is later than the one the previous cluster implies, the probed inputs held still during that span. The block fills the span by repeating the last sample it emitted. Each event word holds one, two or four interleaved samples, depending on the channel mode. The block splits each word into samples and emits them in order.

Clusters belong to memory lines. The event count of a line is given with the first timestamp word of that line, so the last line of a capture can be partial. Words in a cluster beyond the line's remaining events are consumed but produce nothing. Both the word input and the sample output use valid/ready handshakes.

Top module: `cluster_expander`

## Requirements
- R1: After reset, no sample is offered (out_valid low) and the block waits for a timestamp word (in_ready high).
- R2: A timestamp word accepted with in_first high starts a capture. It produces no fill samples, and it latches in_mode for the whole capture. in_mode is ignored on all other words.
- R3: For any later cluster, the fill length is the 16-bit difference (timestamp minus expected timestamp) times the samples per event. Every fill sample equals the last emitted sample.
- R4: After a cluster, the expected timestamp becomes that cluster's timestamp plus EVT_PER_CLU. A cluster that arrives exactly on it produces no fill.
- R5: Sample k of an event word carries word bit i*N+k in output bit i, for i below 16/N, where N is the samples per event. Unused upper output bits are zero. Samples come out for k = 0 upward, and event words are handled in arrival order.
- R6: in_mode 0 gives 1 sample per event, 1 gives 2, and 2 or 3 gives 4.
- R7: Each emitted event sample becomes the last sample used by later fills, including fills that follow a partial cluster.
- R8: A cluster carries min(remaining line events, EVT_PER_CLU) real events. The rest of its EVT_PER_CLU event words are consumed and emit nothing.
- R9: A line ends when its event count is used up, which is after the rounded-up number of clusters. The next timestamp word then loads a fresh in_line_events.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_sample stays unchanged. No sample is lost or duplicated.
- R11: The timestamp difference wraps modulo 2^16, so a cluster whose timestamp passed zero still gets the correct fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_word | input | 16 | Timestamp or event word |
| in_first | input | 1 | Timestamp word opens a new capture |
| in_line_events | input | LE_W (9) | Events in the line; read on a line's first timestamp word |
| in_mode | input | 2 | Channel mode; read with in_first |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the sample |
| out_sample | output | 16 | Expanded sample |

## Verification
The bench sends a one-hot event word for each bit position in every mode. A deinterlacer with a wrong stride or sub-sample offset would therefore put bits in the wrong place or the wrong sample. It checks the following cases:
- Clusters whose timestamps fall exactly on the expected value. A design that forgot the cluster length would insert spurious repeats here.
- Gaps that cross the 16-bit wrap. A non-modular difference would produce an enormous or negative fill.
- A partial cluster whose padding words must vanish, followed by a fill that has to repeat the last real sub-sample. A design that treated padding as data would emit stray samples.
- A mode change on a later timestamp word, which must not change the samples per event.

Random output stalls run throughout. A design that advances on a stalled handshake would drop or duplicate samples.

// File: rtl/cluster_expander_pkg.sv
package cluster_expander_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_TS   = 2'd0,
        ST_FILL = 2'd1,
        ST_EVT  = 2'd2,
        ST_SUB  = 2'd3
    } exp_state_e;

    // log2 of samples per event word for a channel mode code
    function automatic logic [1:0] mode_to_log(input logic [1:0] mode);
        case (mode)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/cluster_deint.sv
module cluster_deint
    import cluster_expander_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        spe_log,
    input  logic [1:0]        sub,
    output logic [WORD_W-1:0] sample
);
    localparam int HALF = WORD_W / 2;
    localparam int QUAR = WORD_W / 4;

    logic [HALF-1:0] s2;
    logic [QUAR-1:0] s4;

    // sample k bit i comes from word bit i*N+k
    for (genvar gi = 0; gi < HALF; gi++) begin : g_two
        assign s2[gi] = word[2*gi + int'(sub[0])];
    end
    for (genvar gi = 0; gi < QUAR; gi++) begin : g_four
        assign s4[gi] = word[4*gi + int'(sub)];
    end

    always_comb begin
        case (spe_log)
            2'd0:    sample = word;
            2'd1:    sample = {{(WORD_W-HALF){1'b0}}, s2};
            default: sample = {{(WORD_W-QUAR){1'b0}}, s4};
        endcase
    end
endmodule

// File: rtl/cluster_gap.sv
module cluster_gap
    import cluster_expander_pkg::*;
#(
    parameter int FILL_W = WORD_W + 2
) (
    input  logic [WORD_W-1:0] ts,
    input  logic [WORD_W-1:0] expect_ts,
    input  logic              first,
    input  logic [1:0]        spe_log,
    output logic [FILL_W-1:0] fill
);
    logic [WORD_W-1:0] diff;

    always_comb begin
        diff = first ? '0 : ts - expect_ts;   // modulo 2^16
        fill = FILL_W'(diff) << spe_log;
    end
endmodule

// File: rtl/cluster_expander.sv
module cluster_expander
    import cluster_expander_pkg::*;
#(
    parameter int EVT_PER_CLU  = 7,
    parameter int CLU_PER_LINE = 64,
    parameter int LE_W         = $clog2(EVT_PER_CLU * CLU_PER_LINE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_first,
    input  logic [LE_W-1:0]   in_line_events,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_sample
);
    localparam int WI_W   = $clog2(EVT_PER_CLU + 1);
    localparam int FILL_W = WORD_W + 2;
    localparam logic [WI_W-1:0]   EPC_WI = WI_W'(EVT_PER_CLU);
    localparam logic [LE_W-1:0]   EPC_LE = LE_W'(EVT_PER_CLU);
    localparam logic [WORD_W-1:0] EPC_TS = WORD_W'(EVT_PER_CLU);

    typedef struct packed {
        exp_state_e        st;
        logic [WORD_W-1:0] exp_ts;
        logic [WORD_W-1:0] last_smp;
        logic [FILL_W-1:0] fill;
        logic [WORD_W-1:0] word;
        logic [1:0]        sub;
        logic [WI_W-1:0]   widx;
        logic [WI_W-1:0]   nevt;
        logic [LE_W-1:0]   rem;
        logic [1:0]        spel;
    } exp_regs_t;

    exp_regs_t r_q, r_d;

    logic [WORD_W-1:0] deint_smp;
    logic [FILL_W-1:0] gap_fill;
    logic [LE_W-1:0]   rem_eff;
    logic [1:0]        sub_last;
    logic              in_fire;
    logic              out_fire;

    cluster_deint u_deint (
        .word    (r_q.word),
        .spe_log (r_q.spel),
        .sub     (r_q.sub),
        .sample  (deint_smp)
    );

    cluster_gap #(.FILL_W(FILL_W)) u_gap (
        .ts        (in_word),
        .expect_ts (r_q.exp_ts),
        .first     (in_first),
        .spe_log   (r_q.spel),
        .fill      (gap_fill)
    );

    always_comb begin
        r_d        = r_q;
        in_ready   = (r_q.st == ST_TS) || (r_q.st == ST_EVT);
        out_valid  = (r_q.st == ST_FILL) || (r_q.st == ST_SUB);
        out_sample = (r_q.st == ST_FILL) ? r_q.last_smp : deint_smp;
        in_fire    = in_valid && in_ready;
        out_fire   = out_valid && out_ready;
        rem_eff    = (in_first || r_q.rem == '0) ? in_line_events : r_q.rem;
        sub_last   = (r_q.spel == 2'd0) ? 2'd0 : (r_q.spel == 2'd1) ? 2'd1 : 2'd3;

        case (r_q.st)
            ST_TS: if (in_fire) begin
                if (rem_eff >= EPC_LE) begin
                    r_d.nevt = EPC_WI;
                    r_d.rem  = rem_eff - EPC_LE;
                end else begin
                    r_d.nevt = WI_W'(rem_eff);
                    r_d.rem  = '0;
                end
                r_d.widx   = '0;
                r_d.exp_ts = in_word + EPC_TS;
                r_d.fill   = gap_fill;
                if (in_first) r_d.spel = mode_to_log(in_mode);
                r_d.st = (gap_fill != '0) ? ST_FILL : ST_EVT;
            end
            ST_FILL: if (out_fire) begin
                r_d.fill = r_q.fill - 1'b1;
                if (r_q.fill == FILL_W'(1)) r_d.st = ST_EVT;
            end
            ST_EVT: if (in_fire) begin
                r_d.widx = r_q.widx + 1'b1;
                if (r_q.widx < r_q.nevt) begin
                    r_d.word = in_word;
                    r_d.sub  = 2'd0;
                    r_d.st   = ST_SUB;
                end else if (r_q.widx == EPC_WI - 1'b1) begin
                    r_d.st = ST_TS;
                end
            end
            ST_SUB: if (out_fire) begin
                r_d.last_smp = deint_smp;
                if (r_q.sub == sub_last) begin
                    r_d.sub = 2'd0;
                    r_d.st  = (r_q.widx == EPC_WI) ? ST_TS : ST_EVT;
                end else begin
                    r_d.sub = r_q.sub + 1'b1;
                end
            end
            default: r_d.st = ST_TS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_TS, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assert_hold_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_sample));

    assert_first_no_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_first && r_q.st == ST_TS |=> !out_valid);

    assert_on_time_no_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_first && r_q.st == ST_TS && in_word == r_q.exp_ts
        |=> !out_valid);

    assert_padding_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && r_q.st == ST_EVT && r_q.widx >= r_q.nevt |=> !out_valid);

    assert_fill_repeats_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_FILL && out_ready && r_q.fill > FILL_W'(1)
        |=> out_valid && out_sample == $past(out_sample));

endmodule

// File: tb/cluster_expander_test.sv
module cluster_expander_test;
    localparam int CLK_PERIOD = 10;
    localparam int EPC = 7;
    localparam int LE_W = 9;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic in_ready;
    logic [15:0] in_word = '0;
    logic in_first = 0;
    logic [LE_W-1:0] in_line_events = '0;
    logic [1:0] in_mode = '0;
    logic out_valid;
    logic out_ready = 0;
    logic [15:0] out_sample;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit always_ready = 0;

    logic [15:0] exp_q[$];
    string tag_q[$];
    logic [15:0] m_last_ts = '0;
    logic [15:0] m_last = '0;
    int m_spe = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cluster_expander uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_first(in_first), .in_line_events(in_line_events),
        .in_mode(in_mode), .out_valid(out_valid), .out_ready(out_ready),
        .out_sample(out_sample)
    );

    function automatic logic [15:0] deint_ref(logic [15:0] w, int k, int n);
        logic [15:0] s = '0;
        for (int i = 0; i < 16 / n; i++) s[i] = w[i*n + k];
        return s;
    endfunction

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send_word(logic [15:0] w, bit first, int le, logic [1:0] mode);
        @(negedge clk);
        in_valid = 1; in_word = w; in_first = first;
        in_line_events = LE_W'(le); in_mode = mode;
        forever begin
            #1;
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic send_cluster(logic [15:0] ts, bit first, logic [1:0] mode, int le,
                                int nevt, logic [15:0] w[EPC], string etag, string ftag);
        logic [15:0] diff;
        logic [15:0] s;
        if (first) begin
            m_spe = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
        end else begin
            diff = ts - m_last_ts;
            for (int j = 0; j < int'(diff) * m_spe; j++) begin
                exp_q.push_back(m_last); tag_q.push_back(ftag);
            end
        end
        for (int e = 0; e < nevt; e++) begin
            for (int k = 0; k < m_spe; k++) begin
                s = deint_ref(w[e], k, m_spe);
                exp_q.push_back(s); tag_q.push_back(etag);
                m_last = s;
            end
        end
        m_last_ts = ts + 16'(EPC);
        // mode on non-first words is noise that must be ignored (R2)
        send_word(ts, first, le, first ? mode : 2'($urandom));
        for (int e = 0; e < EPC; e++) send_word(w[e], 0, 0, 2'($urandom));
    endtask

    task automatic rand_words(output logic [15:0] w[EPC]);
        for (int e = 0; e < EPC; e++) w[e] = 16'($urandom);
    endtask

    // output collector
    initial begin
        forever begin
            @(negedge clk);
            out_ready = always_ready ? 1'b1 : (($urandom % 4) != 0);
            #1;
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 extra sample", out_sample, 16'h0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_sample === e, t, out_sample, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=0 pending", exp_q.size());
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] w[EPC];
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(out_valid == 0, "R1 out_valid in reset", 16'(out_valid), 16'h0);
        rst_n = 1;
        @(negedge clk); #1;
        check(out_valid == 0, "R1 out_valid after reset", 16'(out_valid), 16'h0);
        check(in_ready == 1, "R1 in_ready after reset", 16'(in_ready), 16'h1);

        // mode 0: on-time cluster, gap, new line
        rand_words(w); send_cluster(16'd100, 1, 2'd0, 21, 7, w, "R2 R5", "R2");
        rand_words(w); send_cluster(16'd107, 0, 2'd0, 0, 7, w, "R4", "R4 fill");
        rand_words(w); send_cluster(16'd120, 0, 2'd0, 0, 7, w, "R5", "R3 R7");
        rand_words(w); send_cluster(16'd130, 0, 2'd0, 7, 7, w, "R9", "R3 R7");

        // mode 1: partial cluster with padding, then wrap across zero
        rand_words(w); send_cluster(16'hFFF0, 1, 2'd1, 10, 7, w, "R6 R5", "R2");
        rand_words(w); send_cluster(16'hFFF9, 0, 2'd1, 0, 3, w, "R8", "R3 R7");
        rand_words(w); send_cluster(16'h0003, 0, 2'd1, 5, 5, w, "R9", "R11 R7");
        rand_words(w); send_cluster(16'hFFFE, 1, 2'd1, 14, 7, w, "R2", "R2");
        rand_words(w); send_cluster(16'h0008, 0, 2'd1, 0, 7, w, "R9", "R11");

        // sweep: one-hot words in every mode
        for (int md = 0; md < 4; md++) begin
            for (int c = 0; c < 3; c++) begin
                for (int e = 0; e < EPC; e++)
                    w[e] = (c*EPC + e < 16) ? (16'h1 << (c*EPC + e)) : 16'($urandom);
                send_cluster(16'(200 + 8*c), c == 0, 2'(md), c == 0 ? 21 : 0, 7, w,
                             "R5 R6", "R3");
            end
        end

        // large gap with full-rate consumer
        always_ready = 1;
        rand_words(w); send_cluster(16'h1000, 1, 2'd2, 14, 7, w, "R5", "R2");
        rand_words(w); send_cluster(16'h1000 + 16'd7 + 16'd1000, 0, 2'd2, 0, 7, w,
                                    "R5", "R3 R10");
        always_ready = 0;

        @(negedge clk); in_valid = 0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (30) begin
            @(negedge clk); #1;
            check(out_valid == 0, "R8 no trailing output", 16'(out_valid), 16'h0);
        end
        check(exp_q.size() == 0, "R10 all samples delivered", 16'(exp_q.size()), 16'h0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule